// File: doc/BRIEF.md
# Five-Port Micro-Op Dispatch Scheduler

This block holds renamed micro-ops until their source operands are available and an execution unit of the right kind can take them. Every cycle it picks up to five micro-ops, at most one for each of five dispatch ports, and presents them on the port outputs. Port 0 is shared by an integer unit and the floating-point unit. Port 1 feeds a second integer unit. Port 2 feeds the load address unit, port 3 the store address unit and port 4 the store data path. A store therefore arrives from rename as two separate micro-ops, and these can leave in the same cycle.

Each entry carries a sequence stamp that gives its program order. The stamp comparison wraps, so live stamps must lie within half the stamp range of each other. When several ready micro-ops want the same port, the oldest one goes. A tag broadcast from completing producers marks matching sources ready. An entry that a broadcast wakes can leave no sooner than the next cycle. A flush drops every entry younger than a given stamp.

Dispatch is combinational from the stored entries and the busy inputs. A dispatched entry leaves the scheduler at the next clock edge.

Top module: `dispatch_sched`

## Requirements
- R1: After reset no port dispatches and in_ready is 1.
- R2: Class codes are 0 integer, 1 floating point, 2 load, 3 store address and 4 store data. Port 0 dispatches classes 0 and 1, port 1 class 0, port 2 class 2, port 3 class 3 and port 4 class 4. dp_cls gives the class of the micro-op on each port.
- R3: An entry can dispatch only when both of its sources are ready and the unit it needs is not busy. Busy bits are: bit 0 integer unit on port 0, bit 1 floating point, bit 2 integer unit on port 1, bit 3 load, bit 4 store address, bit 5 store data.
- R4: A busy bit blocks only its own unit. With the floating-point unit busy, port 0 can still take integer work, and with the port 0 integer unit busy it can still take floating-point work.
- R5: Among the eligible entries competing for a port, the one with the oldest stamp wins. Stamp a is older than stamp b when (a-b) modulo 2^SEQW has its top bit set, so the comparison works across stamp wrap.
- R6: The oldest eligible integer micro-op goes to port 1 when that unit is free. Port 0 then takes the older of the next eligible integer micro-op and the oldest eligible floating-point micro-op.
- R7: A broadcast of a tag marks every matching source ready, including the sources of a micro-op being inserted in the same cycle. A micro-op that a broadcast wakes dispatches at the earliest in the cycle after the broadcast.
- R8: Up to five micro-ops dispatch in one cycle. A load, a store address and a store data micro-op can all leave together.
- R9: in_ready is 0 while all DEPTH entries are occupied, and an insert offered while in_ready is 0 is ignored.
- R10: With flush_valid high, entries whose stamp is younger than flush_seq neither dispatch in that cycle nor later. An insert in that cycle with a younger stamp is dropped. Entries with an equal or older stamp are kept.
- R11: Each inserted micro-op dispatches exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Insert request from rename |
| in_ready | output | 1 | A free entry exists |
| in_cls | input | 3 | Class code of the inserted micro-op |
| in_seq | input | SEQW | Program-order stamp |
| in_src0_tag | input | TAGW | Tag of the first source |
| in_src0_rdy | input | 1 | First source already available |
| in_src1_tag | input | TAGW | Tag of the second source |
| in_src1_rdy | input | 1 | Second source already available |
| bc_valid | input | 1 | Result tag broadcast valid |
| bc_tag | input | TAGW | Broadcast result tag |
| unit_busy | input | 6 | Per-unit busy flags |
| flush_valid | input | 1 | Flush request |
| flush_seq | input | SEQW | Stamp at which the flush applies; younger entries are dropped |
| dp_valid | output | 5 | Per-port dispatch valid |
| dp_seq | output | 5 x SEQW | Stamp of the micro-op on each port |
| dp_cls | output | 5 x 3 | Class of the micro-op on each port |

## Verification
Several properties are checked on every cycle: that each port carries only its own classes, that no busy unit receives work, that the two integer ports never break age order, that a flush never lets a younger stamp out, and that in_ready only falls after an insert was offered. Other behaviours span several cycles, and only the bench scenarios show them: the one-cycle wakeup delay, exact age order across stamp wrap, the removal of flushed work, the ignoring of an insert while full, and exactly-once dispatch. The bench compares every port against its own reference model under random traffic, and directed cases cover each of these behaviours.

// File: rtl/sched_pkg.sv
package sched_pkg;
   typedef enum logic [2:0] {
      UOP_INT  = 3'd0,
      UOP_FP   = 3'd1,
      UOP_LOAD = 3'd2,
      UOP_STA  = 3'd3,
      UOP_STD  = 3'd4
   } uop_cls_e;

   localparam int NUM_PORTS = 5;
   localparam int NUM_UNITS = 6;
   localparam int NUM_CLS   = 5;
   localparam int NUM_AGU   = 3;   // ports 2..4 each serve exactly one class

   localparam int U_INT0 = 0;
   localparam int U_FP   = 1;
   localparam int U_INT1 = 2;
   localparam int U_LOAD = 3;
endpackage

// File: rtl/sched_age_picker.sv
module sched_age_picker #(
   parameter int N  = 8,
   parameter int SW = 8
) (
   input  logic [N-1:0]         req,
   input  logic [N-1:0][SW-1:0] seq,
   output logic [N-1:0]         gnt
);
   function automatic logic older(input logic [SW-1:0] a, input logic [SW-1:0] b);
      logic [SW-1:0] d;
      d = a - b;
      return d[SW-1];
   endfunction

   always_comb begin
      for (int i = 0; i < N; i++) begin
         gnt[i] = req[i];
         for (int j = 0; j < N; j++) begin
            if (j != i && req[j] && older(seq[j], seq[i]))
               gnt[i] = 1'b0;
         end
      end
   end
endmodule

// File: rtl/sched_slot_alloc.sv
module sched_slot_alloc #(
   parameter int N  = 8,
   parameter int IW = 3
) (
   input  logic [N-1:0]  used,
   output logic          any_free,
   output logic [IW-1:0] idx
);
   always_comb begin
      any_free = ~&used;
      idx      = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (!used[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/sched_port_mux.sv
module sched_port_mux #(
   parameter int N  = 8,
   parameter int SW = 8
) (
   input  logic [N-1:0]         gnt,
   input  logic [N-1:0][SW-1:0] seq,
   input  logic [N-1:0][2:0]    cls,
   output logic                 vld,
   output logic [SW-1:0]        seq_o,
   output logic [2:0]           cls_o
);
   always_comb begin
      vld   = |gnt;
      seq_o = '0;
      cls_o = '0;
      for (int i = 0; i < N; i++) begin
         if (gnt[i]) begin
            seq_o = seq_o | seq[i];
            cls_o = cls_o | cls[i];
         end
      end
   end
endmodule

// File: rtl/dispatch_sched.sv
module dispatch_sched
   import sched_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int SEQW  = 8,
   parameter int TAGW  = 4
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           in_valid,
   output logic                           in_ready,
   input  logic [2:0]                     in_cls,
   input  logic [SEQW-1:0]                in_seq,
   input  logic [TAGW-1:0]                in_src0_tag,
   input  logic                           in_src0_rdy,
   input  logic [TAGW-1:0]                in_src1_tag,
   input  logic                           in_src1_rdy,
   input  logic                           bc_valid,
   input  logic [TAGW-1:0]                bc_tag,
   input  logic [5:0]                     unit_busy,
   input  logic                           flush_valid,
   input  logic [SEQW-1:0]                flush_seq,
   output logic [4:0]                     dp_valid,
   output logic [4:0][SEQW-1:0]           dp_seq,
   output logic [4:0][2:0]                dp_cls
);
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   function automatic logic seq_older(input logic [SEQW-1:0] a, input logic [SEQW-1:0] b);
      logic [SEQW-1:0] d;
      d = a - b;
      return d[SEQW-1];
   endfunction

   // entry storage
   logic [DEPTH-1:0]            e_vld, e_r0, e_r1;
   logic [DEPTH-1:0][SEQW-1:0]  e_seq;
   logic [DEPTH-1:0][TAGW-1:0]  e_t0, e_t1;
   logic [DEPTH-1:0][2:0]       e_cls;

   logic [DEPTH-1:0] kill, elig, taken;
   logic [DEPTH-1:0] req_p0, req_p1, gnt_p0, gnt_p1;
   logic [DEPTH-1:0] cls_vec [NUM_CLS];
   logic [DEPTH-1:0] gnt_all [NUM_PORTS];
   logic             free_any, ins_fire;
   logic [IW-1:0]    ins_idx;

   genvar gc, gi, gk, gp;
   generate
      for (gc = 0; gc < NUM_CLS; gc++) begin : g_cls
         for (gi = 0; gi < DEPTH; gi++) begin : g_ent
            assign cls_vec[gc][gi] = (e_cls[gi] == 3'(gc));
         end
      end
   endgenerate

   always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
         kill[i] = e_vld[i] & flush_valid & seq_older(flush_seq, e_seq[i]);
         elig[i] = e_vld[i] & ~kill[i] & e_r0[i] & e_r1[i];
      end
      req_p1 = elig & cls_vec[UOP_INT] & {DEPTH{~unit_busy[U_INT1]}};
   end

   sched_age_picker #(.N(DEPTH), .SW(SEQW)) u_pick_p1 (.req(req_p1), .seq(e_seq), .gnt(gnt_p1));

   // shared port: integer work not already on port 1, and floating-point work, by age
   always_comb begin
      req_p0 = (elig & cls_vec[UOP_INT] & ~gnt_p1 & {DEPTH{~unit_busy[U_INT0]}})
             | (elig & cls_vec[UOP_FP] & {DEPTH{~unit_busy[U_FP]}});
   end

   sched_age_picker #(.N(DEPTH), .SW(SEQW)) u_pick_p0 (.req(req_p0), .seq(e_seq), .gnt(gnt_p0));

   assign gnt_all[0] = gnt_p0;
   assign gnt_all[1] = gnt_p1;

   generate
      for (gk = 0; gk < NUM_AGU; gk++) begin : g_agu
         logic [DEPTH-1:0] req_k;
         assign req_k = elig & cls_vec[UOP_LOAD + gk] & {DEPTH{~unit_busy[U_LOAD + gk]}};
         sched_age_picker #(.N(DEPTH), .SW(SEQW)) u_pick (.req(req_k), .seq(e_seq), .gnt(gnt_all[2 + gk]));
      end
      for (gp = 0; gp < NUM_PORTS; gp++) begin : g_port
         sched_port_mux #(.N(DEPTH), .SW(SEQW)) u_mux (
            .gnt(gnt_all[gp]), .seq(e_seq), .cls(e_cls),
            .vld(dp_valid[gp]), .seq_o(dp_seq[gp]), .cls_o(dp_cls[gp]));
      end
   endgenerate

   always_comb begin
      taken = '0;
      for (int p = 0; p < NUM_PORTS; p++) taken = taken | gnt_all[p];
   end

   sched_slot_alloc #(.N(DEPTH), .IW(IW)) u_alloc (.used(e_vld), .any_free(free_any), .idx(ins_idx));

   assign in_ready = free_any;
   assign ins_fire = in_valid & free_any & ~(flush_valid & seq_older(flush_seq, in_seq));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         e_vld <= '0;
         e_r0  <= '0;
         e_r1  <= '0;
         e_seq <= '0;
         e_t0  <= '0;
         e_t1  <= '0;
         e_cls <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (taken[i] | kill[i]) e_vld[i] <= 1'b0;
            if (bc_valid && e_t0[i] == bc_tag) e_r0[i] <= 1'b1;
            if (bc_valid && e_t1[i] == bc_tag) e_r1[i] <= 1'b1;
         end
         if (ins_fire) begin
            e_vld[ins_idx] <= 1'b1;
            e_cls[ins_idx] <= in_cls;
            e_seq[ins_idx] <= in_seq;
            e_t0[ins_idx]  <= in_src0_tag;
            e_t1[ins_idx]  <= in_src1_tag;
            e_r0[ins_idx]  <= in_src0_rdy | (bc_valid && in_src0_tag == bc_tag);
            e_r1[ins_idx]  <= in_src1_rdy | (bc_valid && in_src1_tag == bc_tag);
         end
      end
   end
endmodule

// File: rtl/dispatch_sched_chk.sv
module dispatch_sched_chk #(
   parameter int DEPTH = 8,
   parameter int SEQW  = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_valid,
   input logic                 in_ready,
   input logic [5:0]           unit_busy,
   input logic                 flush_valid,
   input logic [SEQW-1:0]      flush_seq,
   input logic [4:0]           dp_valid,
   input logic [4:0][SEQW-1:0] dp_seq,
   input logic [4:0][2:0]      dp_cls
);
   function automatic logic older(input logic [SEQW-1:0] a, input logic [SEQW-1:0] b);
      logic [SEQW-1:0] d;
      d = a - b;
      return d[SEQW-1];
   endfunction

   initial begin
      a_param_shape: assert (DEPTH >= 2 && SEQW > $clog2(DEPTH) + 1)
         else $error("scheduler parameters out of range");
   end

   a_r2_port0_class: assert property (@(posedge clk) disable iff (!rst_n)
      dp_valid[0] |-> (dp_cls[0] == 3'd0 || dp_cls[0] == 3'd1));
   a_r2_port1_class: assert property (@(posedge clk) disable iff (!rst_n)
      dp_valid[1] |-> dp_cls[1] == 3'd0);
   a_r2_agu_class: assert property (@(posedge clk) disable iff (!rst_n)
      (dp_valid[2] |-> dp_cls[2] == 3'd2) and (dp_valid[3] |-> dp_cls[3] == 3'd3)
      and (dp_valid[4] |-> dp_cls[4] == 3'd4));

   a_r4_int0_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (dp_valid[0] && dp_cls[0] == 3'd0) |-> !unit_busy[0]);
   a_r4_fp_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (dp_valid[0] && dp_cls[0] == 3'd1) |-> !unit_busy[1]);
   a_r3_unit_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (unit_busy[2] |-> !dp_valid[1]) and (unit_busy[3] |-> !dp_valid[2])
      and (unit_busy[4] |-> !dp_valid[3]) and (unit_busy[5] |-> !dp_valid[4]));

   a_r6_int_order: assert property (@(posedge clk) disable iff (!rst_n)
      (dp_valid[0] && dp_valid[1] && dp_cls[0] == 3'd0) |-> older(dp_seq[1], dp_seq[0]));

   a_r9_full_follows_insert: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(in_ready) |-> $past(in_valid));

   genvar gp;
   generate
      for (gp = 0; gp < 5; gp++) begin : g_fl
         a_r10_no_young_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
            (flush_valid && dp_valid[gp]) |-> !older(flush_seq, dp_seq[gp]));
      end
   endgenerate
endmodule

bind dispatch_sched dispatch_sched_chk #(.DEPTH(DEPTH), .SEQW(SEQW)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .unit_busy(unit_busy), .flush_valid(flush_valid), .flush_seq(flush_seq),
   .dp_valid(dp_valid), .dp_seq(dp_seq), .dp_cls(dp_cls));

// File: tb/dispatch_sched_test.sv
module dispatch_sched_test;
   localparam int D    = 8;
   localparam int SEQW = 8;
   localparam int TAGW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic in_ready;
   logic [2:0] in_cls = '0;
   logic [SEQW-1:0] in_seq = '0;
   logic [TAGW-1:0] in_src0_tag = '0, in_src1_tag = '0;
   logic in_src0_rdy = 1'b0, in_src1_rdy = 1'b0;
   logic bc_valid = 1'b0;
   logic [TAGW-1:0] bc_tag = '0;
   logic [5:0] unit_busy = '0;
   logic flush_valid = 1'b0;
   logic [SEQW-1:0] flush_seq = '0;
   logic [4:0] dp_valid;
   logic [4:0][SEQW-1:0] dp_seq;
   logic [4:0][2:0] dp_cls;

   dispatch_sched #(.DEPTH(D), .SEQW(SEQW), .TAGW(TAGW)) uut (.*);

   always #5 clk = ~clk;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;
   string cur_req = "R1";

   // reference model
   bit m_v[D], m_r0[D], m_r1[D];
   logic [SEQW-1:0] m_seq[D];
   logic [TAGW-1:0] m_t0[D], m_t1[D];
   int m_cls[D];

   // last samples
   logic [4:0] s_dv;
   logic [SEQW-1:0] s_seq[5];
   logic [2:0] s_cls[5];
   logic s_rdy;
   int n_disp = 0;
   logic [SEQW-1:0] watch = '0;
   bit saw_watch = 0;

   function automatic bit b_older(logic [SEQW-1:0] a, logic [SEQW-1:0] b);
      logic [SEQW-1:0] d;
      d = a - b;
      return d[SEQW-1];
   endfunction

   function automatic int pick(bit [D-1:0] mk);
      int b = -1;
      for (int i = 0; i < D; i++)
         if (mk[i] && (b < 0 || b_older(m_seq[i], m_seq[b]))) b = i;
      return b;
   endfunction

   function automatic int m_count();
      int c = 0;
      for (int i = 0; i < D; i++) c += m_v[i];
      return c;
   endfunction

   task automatic chk(bit ok, string req, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic model_clear();
      for (int i = 0; i < D; i++) m_v[i] = 0;
   endtask

   // one clock: inputs already driven after a falling edge
   task automatic tick();
      bit kl[D];
      bit [D-1:0] mk1, mk0, mka[3];
      int w[5];
      int cnt;
      #4;
      cnt = m_count();
      for (int i = 0; i < D; i++)
         kl[i] = m_v[i] && flush_valid && b_older(flush_seq, m_seq[i]);
      for (int i = 0; i < D; i++) begin
         bit el;
         el = m_v[i] && !kl[i] && m_r0[i] && m_r1[i];
         mk1[i] = el && m_cls[i] == 0 && !unit_busy[2];
         for (int k = 0; k < 3; k++) mka[k][i] = el && m_cls[i] == 2 + k && !unit_busy[3 + k];
      end
      w[1] = pick(mk1);
      for (int i = 0; i < D; i++) begin
         bit el;
         el = m_v[i] && !kl[i] && m_r0[i] && m_r1[i];
         mk0[i] = el && ((m_cls[i] == 0 && !unit_busy[0] && i != w[1]) || (m_cls[i] == 1 && !unit_busy[1]));
      end
      w[0] = pick(mk0);
      for (int k = 0; k < 3; k++) w[2 + k] = pick(mka[k]);

      s_dv = dp_valid;
      s_rdy = in_ready;
      for (int p = 0; p < 5; p++) begin
         bit ev, ok;
         s_seq[p] = dp_seq[p];
         s_cls[p] = dp_cls[p];
         ev = w[p] >= 0;
         ok = (dp_valid[p] == ev) && (!ev || (dp_seq[p] == m_seq[w[p]] && int'(dp_cls[p]) == m_cls[w[p]]));
         chk(ok, cur_req, $sformatf("port%0d valid/seq", p),
             dp_valid[p] ? int'(dp_seq[p]) : -1, ev ? int'(m_seq[w[p]]) : -1);
         if (dp_valid[p]) begin
            n_disp++;
            if (dp_seq[p] == watch) saw_watch = 1;
         end
      end
      chk(in_ready == (cnt < D), "R9", "in_ready", int'(in_ready), int'(cnt < D));

      @(posedge clk);
      for (int i = 0; i < D; i++) begin
         if (kl[i]) m_v[i] = 0;
         for (int p = 0; p < 5; p++) if (w[p] == i) m_v[i] = 0;
         if (bc_valid && m_t0[i] == bc_tag) m_r0[i] = 1;
         if (bc_valid && m_t1[i] == bc_tag) m_r1[i] = 1;
      end
      if (in_valid && cnt < D && !(flush_valid && b_older(flush_seq, in_seq))) begin
         int j = -1;
         for (int i = D - 1; i >= 0; i--) if (!m_v[i]) j = i;
         m_v[j] = 1; m_cls[j] = int'(in_cls); m_seq[j] = in_seq;
         m_t0[j] = in_src0_tag; m_t1[j] = in_src1_tag;
         m_r0[j] = in_src0_rdy || (bc_valid && in_src0_tag == bc_tag);
         m_r1[j] = in_src1_rdy || (bc_valid && in_src1_tag == bc_tag);
      end
      @(negedge clk);
   endtask

   task automatic idle_inputs();
      in_valid = 0; bc_valid = 0; flush_valid = 0;
   endtask

   task automatic do_reset();
      idle_inputs();
      unit_busy = '0;
      rst_n = 0;
      model_clear();
      @(negedge clk); @(negedge clk);
      rst_n = 1;
   endtask

   task automatic ins(int c, int s, int t0, bit r0, int t1, bit r1);
      in_valid = 1; in_cls = 3'(c); in_seq = SEQW'(s);
      in_src0_tag = TAGW'(t0); in_src0_rdy = r0;
      in_src1_tag = TAGW'(t1); in_src1_rdy = r1;
      tick();
      in_valid = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [SEQW-1:0] next_seq;
      void'($urandom(32'd20240611));
      @(negedge clk);

      // R1 reset state
      do_reset();
      cur_req = "R1";
      #4;
      chk(dp_valid == 5'b0 && in_ready == 1'b1, "R1", "reset outputs", int'({dp_valid, in_ready}), 1);
      @(negedge clk);

      // R3 operand readiness gates dispatch
      do_reset(); cur_req = "R3";
      ins(2, 50, 0, 1, 6, 0);
      tick();
      chk(s_dv[2] == 0, "R3", "load with pending source", int'(s_dv[2]), 0);
      bc_valid = 1; bc_tag = 6; tick(); bc_valid = 0;
      tick();
      chk(s_dv[2] == 1 && s_seq[2] == 50, "R3", "load after wake", int'(s_seq[2]), 50);

      // R7 wakeup timing
      do_reset(); cur_req = "R7";
      ins(0, 1, 3, 0, 0, 1);
      bc_valid = 1; bc_tag = 3; tick(); bc_valid = 0;
      chk(s_dv[1] == 0, "R7", "no dispatch in broadcast cycle", int'(s_dv[1]), 0);
      tick();
      chk(s_dv[1] == 1 && s_seq[1] == 1, "R7", "dispatch cycle after broadcast", int'(s_seq[1]), 1);
      bc_valid = 1; bc_tag = 4;
      ins(0, 2, 4, 0, 0, 1);
      bc_valid = 0;
      tick();
      chk(s_dv[1] == 1 && s_seq[1] == 2, "R7", "wake during insert", int'(s_seq[1]), 2);

      // R8 five-wide dispatch
      do_reset(); cur_req = "R8";
      unit_busy = 6'h3F;
      ins(2, 2, 0, 1, 0, 1); ins(3, 3, 0, 1, 0, 1); ins(4, 4, 0, 1, 0, 1);
      ins(0, 5, 0, 1, 0, 1); ins(1, 6, 0, 1, 0, 1);
      unit_busy = '0;
      tick();
      chk(s_dv == 5'b11111, "R8", "all ports valid", int'(s_dv), 31);
      chk(s_seq[0] == 6 && s_seq[1] == 5 && s_seq[2] == 2 && s_seq[3] == 3 && s_seq[4] == 4,
          "R8", "port stamps p0", int'(s_seq[0]), 6);
      chk(s_cls[0] == 1 && s_cls[3] == 3, "R2", "port class codes", int'(s_cls[0]), 1);

      // R6 and R5 integer ordering over two ports
      do_reset(); cur_req = "R6";
      unit_busy = 6'h3F;
      ins(0, 10, 0, 1, 0, 1); ins(0, 11, 0, 1, 0, 1); ins(0, 12, 0, 1, 0, 1); ins(1, 13, 0, 1, 0, 1);
      unit_busy = '0;
      tick();
      chk(s_seq[1] == 10 && s_seq[0] == 11, "R6", "first pair p1", int'(s_seq[1]), 10);
      tick();
      chk(s_seq[1] == 12 && s_seq[0] == 13 && s_cls[0] == 1, "R5", "second pair p0", int'(s_seq[0]), 13);

      // R4 busy isolation on the shared port
      do_reset(); cur_req = "R4";
      unit_busy = 6'h3F;
      ins(0, 20, 0, 1, 0, 1); ins(1, 21, 0, 1, 0, 1);
      unit_busy = 6'b000110;
      tick();
      chk(s_dv[1] == 0 && s_dv[0] == 1 && s_seq[0] == 20 && s_cls[0] == 0, "R4", "int on shared port with fp busy", int'(s_seq[0]), 20);
      unit_busy = 6'b000001;
      tick();
      chk(s_dv[0] == 1 && s_seq[0] == 21 && s_cls[0] == 1, "R4", "fp with int0 busy", int'(s_seq[0]), 21);

      // R5 age across stamp wrap
      do_reset(); cur_req = "R5";
      unit_busy = 6'h3F;
      ins(0, 1, 0, 1, 0, 1); ins(0, 254, 0, 1, 0, 1);
      unit_busy = 6'b000001;
      tick();
      chk(s_dv[1] == 1 && s_seq[1] == 254, "R5", "wrapped age order", int'(s_seq[1]), 254);
      tick();
      chk(s_dv[1] == 1 && s_seq[1] == 1, "R5", "younger after wrap", int'(s_seq[1]), 1);

      // R9 and R11 capacity, ignored insert, exactly once
      do_reset(); cur_req = "R9";
      unit_busy = 6'h3F;
      for (int k = 0; k < D; k++) ins(0, 30 + k, 0, 1, 0, 1);
      watch = 30 + D; saw_watch = 0;
      ins(0, 30 + D, 0, 1, 0, 1);
      chk(s_rdy == 0, "R9", "full in_ready", int'(s_rdy), 0);
      unit_busy = '0; n_disp = 0; cur_req = "R11";
      for (int k = 0; k < D; k++) tick();
      chk(n_disp == D, "R11", "dispatch count", n_disp, D);
      chk(saw_watch == 0, "R9", "insert while full ignored", int'(saw_watch), 0);

      // R10 flush
      do_reset(); cur_req = "R10";
      ins(0, 40, 5, 0, 0, 1); ins(0, 41, 5, 0, 0, 1); ins(0, 42, 5, 0, 0, 1);
      n_disp = 0; watch = 40; saw_watch = 0;
      flush_valid = 1; flush_seq = 40;
      ins(0, 43, 0, 1, 0, 1);
      flush_valid = 0;
      bc_valid = 1; bc_tag = 5;
      for (int k = 0; k < 5; k++) begin tick(); bc_valid = 0; end
      chk(n_disp == 1, "R10", "only survivor dispatches", n_disp, 1);
      chk(saw_watch == 1, "R10", "equal stamp kept", int'(saw_watch), 1);

      // random traffic against the model
      do_reset(); cur_req = "R5 R6 R8";
      next_seq = '0;
      for (int cyc = 0; cyc < 3000; cyc++) begin
         bit win_ok = 1;
         for (int i = 0; i < D; i++)
            if (m_v[i] && SEQW'(next_seq - m_seq[i]) >= 64) win_ok = 0;
         for (int b = 0; b < 6; b++) unit_busy[b] = ($urandom % 4) == 0;
         bc_valid = ($urandom % 10) < 7;
         bc_tag = TAGW'($urandom % 8);
         flush_valid = ($urandom % 33) == 0;
         flush_seq = next_seq - SEQW'(1 + $urandom % 4);
         in_valid = win_ok && (($urandom % 10) < 7);
         in_cls = 3'($urandom % 5);
         in_seq = next_seq;
         in_src0_tag = TAGW'($urandom % 8); in_src0_rdy = $urandom % 2;
         in_src1_tag = TAGW'($urandom % 8); in_src1_rdy = $urandom % 2;
         if (in_valid && m_count() < D) next_seq = next_seq + 1'b1;
         tick();
      end
      idle_inputs();

      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule